// File: doc/BRIEF.md
# Packet Header Trace Record Formatter

This block takes one captured packet header at a time, made of four 32-bit header dwords, an optional prefix dword and the value of a free-running timestamp counter, and turns it into a trace record. The record leaves the block as a stream of 32-bit words under a valid/ready handshake. The final word of each record carries a last marker.

A one-bit format select picks the record layout. Code 0, which is the normal setting, gives a compact record of four words. Code 1 gives a full record of eight words. The compact layout packs selected fields of header dword 0 and the low 11 timestamp bits into a single word. The full layout opens with an all-ones marker word, so that a reader can tell the two layouts apart. The format code and the timestamp are both captured in the cycle in which the header is accepted.

The block accepts one header, then emits its whole record. It accepts no new header until the last word of that record has been handed off.

Top module: `trace_rec_fmt`

## Requirements
- R1: While reset is asserted and after it is released, `outValid` is 0 and `hdrReady` is 1.
- R2: With `fmtSel`=0, a record is 4 words long and `outLast` is 1 only on the fourth word.
- R3: With `fmtSel`=1, a record is 8 words long and `outLast` is 1 only on the eighth word.
- R4: The full record is emitted in this order: marker, prefix, header dword 0, header dword 1, header dword 2, header dword 3, a zero word, then the 32-bit timestamp.
- R5: Word 0 of a full record is 0xFFFFFFFF: bits 31:11 are 0x1FFFFF and bits 10:0 are 0x7FF.
- R6: When `pfxPresent` is 0, the prefix word of a full record is 0x00000000. When it is 1, the prefix word is `pfxWord`.
- R7: Word 0 of a compact record is packed from header dword 0 (h0) and the timestamp (ts) as follows: [31:30]=h0[30:29], [29:25]=h0[28:24], [24]=h0[23], [23]=h0[19], [22]=h0[16], [21]=h0[13], [20:11]=h0[9:0], [10:0]=ts[10:0].
- R8: Words 1 to 3 of a compact record are header dwords 1 to 3, unchanged.
- R9: The timestamp placed in a record is the `tsCount` value at the clock edge where the header is accepted, however long the output is stalled afterwards.
- R10: While `outValid` is 1 and `outReady` is 0, `outWord` and `outLast` hold steady and `outValid` stays 1.
- R11: `hdrReady` is 0 while a record is pending. It returns to 1 in the cycle after the last word is handed off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | A header is offered |
| hdrReady | output | 1 | The formatter can accept a header |
| hdrDw0 | input | 32 | Header dword 0 |
| hdrDw1 | input | 32 | Header dword 1 |
| hdrDw2 | input | 32 | Header dword 2 |
| hdrDw3 | input | 32 | Header dword 3 |
| pfxWord | input | 32 | Prefix dword |
| pfxPresent | input | 1 | The prefix dword is valid |
| fmtSel | input | 1 | 0 = compact 4-word record, 1 = full 8-word record |
| tsCount | input | 32 | Free-running timestamp |
| outValid | output | 1 | A record word is presented |
| outReady | input | 1 | The sink takes the word |
| outWord | output | 32 | Record word |
| outLast | output | 1 | The word is the final word of its record |

## Verification
Word 0 of a record appears in the cycle after the accepting edge, because the capture registers and the state are written at that edge. Each later word appears one cycle after the previous word's handoff edge, and `hdrReady` rises one cycle after the final handoff. The bench drives every input on the falling edge and samples on the next falling edge, so each result is read half a cycle after the edge that produces it. The timestamp the bench expects is the counter value it reads just before the accepting edge, and stalled words are read again after a full cycle with ready low.

// File: rtl/trace_rec_pkg.sv
package trace_rec_pkg;
  localparam int WORD_W   = 32;
  localparam int IDX_W    = 3;
  localparam int COMPACT_N = 4;
  localparam int FULL_N    = 8;

  typedef struct packed {
    logic             load;  // capture header, prefix and timestamp
    logic             full;  // record in flight uses the 8-word layout
    logic [IDX_W-1:0] idx;   // word position inside the record
  } rec_ctrl_t;
endpackage

// File: rtl/trace_rec_ctrl.sv
module trace_rec_ctrl
  import trace_rec_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hdrValid,
  input  logic      fmtSel,
  input  logic      outReady,
  output logic      hdrReady,
  output logic      outValid,
  output logic      outLast,
  output rec_ctrl_t ctrl
);
  localparam logic [IDX_W-1:0] LAST_COMPACT = IDX_W'(COMPACT_N - 1);
  localparam logic [IDX_W-1:0] LAST_FULL    = IDX_W'(FULL_N - 1);

  logic             busyQ;
  logic             fullQ;
  logic [IDX_W-1:0] idxQ;
  logic             accept;
  logic             handoff;
  logic             atLast;

  assign accept  = hdrValid && !busyQ;
  assign handoff = busyQ && outReady;
  assign atLast  = idxQ == (fullQ ? LAST_FULL : LAST_COMPACT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      fullQ <= 1'b0;
      idxQ  <= '0;
    end else if (accept) begin
      busyQ <= 1'b1;
      fullQ <= fmtSel;
      idxQ  <= '0;
    end else if (handoff) begin
      if (atLast) busyQ <= 1'b0;
      else        idxQ  <= idxQ + 1'b1;
    end
  end

  assign hdrReady  = !busyQ;
  assign outValid  = busyQ;
  assign outLast   = busyQ && atLast;
  assign ctrl.load = accept;
  assign ctrl.full = fullQ;
  assign ctrl.idx  = idxQ;

  // R10: a stalled word stays presented
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outLast));
  // R11: no header accepted while a record is pending
  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !hdrReady);
  // R11: ready returns right after the final handoff
  p_ready_after_last_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast |=> hdrReady && !outValid);
  // R2, R3: last marker only on a presented word
  p_last_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);
endmodule

// File: rtl/trace_rec_dp.sv
module trace_rec_dp
  import trace_rec_pkg::*;
#(
  parameter int HDR_N = 4,
  parameter int TS_W  = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [HDR_N-1:0][WORD_W-1:0] hdrIn,
  input  logic [WORD_W-1:0]            pfxIn,
  input  logic                         pfxPresent,
  input  logic [TS_W-1:0]              tsIn,
  input  rec_ctrl_t                    ctrl,
  input  logic                         outValid,
  input  logic                         outReady,
  output logic [WORD_W-1:0]            wordOut
);
  localparam int LOW_TS_W = 11;

  logic [HDR_N-1:0][WORD_W-1:0] hdrQ;
  logic [WORD_W-1:0]            pfxQ;
  logic [TS_W-1:0]              tsQ;
  logic [WORD_W-1:0]            compact0;

  for (genvar g = 0; g < HDR_N; g++) begin : g_hdr
    always_ff @(posedge clk) begin
      if (!rstN)          hdrQ[g] <= '0;
      else if (ctrl.load) hdrQ[g] <= hdrIn[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pfxQ <= '0;
      tsQ  <= '0;
    end else if (ctrl.load) begin
      pfxQ <= pfxPresent ? pfxIn : '0;
      tsQ  <= tsIn;
    end
  end

  assign compact0 = {hdrQ[0][30:29], hdrQ[0][28:24], hdrQ[0][23], hdrQ[0][19],
                     hdrQ[0][16], hdrQ[0][13], hdrQ[0][9:0], tsQ[LOW_TS_W-1:0]};

  always_comb begin
    wordOut = '0;
    if (ctrl.full) begin
      case (ctrl.idx)
        3'd0:    wordOut = '1;
        3'd1:    wordOut = pfxQ;
        3'd2:    wordOut = hdrQ[0];
        3'd3:    wordOut = hdrQ[1];
        3'd4:    wordOut = hdrQ[2];
        3'd5:    wordOut = hdrQ[3];
        3'd6:    wordOut = '0;
        default: wordOut = WORD_W'(tsQ);
      endcase
    end else begin
      case (ctrl.idx)
        3'd0:    wordOut = compact0;
        3'd1:    wordOut = hdrQ[1];
        3'd2:    wordOut = hdrQ[2];
        default: wordOut = hdrQ[3];
      endcase
    end
  end

  // R10: the presented word does not change while stalled
  p_word_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(wordOut));
  // R9: captured state is frozen while a record is pending
  p_ts_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> outValid ? $stable(tsQ) : 1'b1);
endmodule

// File: rtl/trace_rec_fmt.sv
module trace_rec_fmt
  import trace_rec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hdrValid,
  output logic        hdrReady,
  input  logic [31:0] hdrDw0,
  input  logic [31:0] hdrDw1,
  input  logic [31:0] hdrDw2,
  input  logic [31:0] hdrDw3,
  input  logic [31:0] pfxWord,
  input  logic        pfxPresent,
  input  logic        fmtSel,
  input  logic [31:0] tsCount,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] outWord,
  output logic        outLast
);
  rec_ctrl_t ctrl;

  trace_rec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .fmtSel(fmtSel),
    .outReady(outReady), .hdrReady(hdrReady), .outValid(outValid),
    .outLast(outLast), .ctrl(ctrl)
  );

  trace_rec_dp #(.HDR_N(4), .TS_W(32)) u_dp (
    .clk(clk), .rstN(rstN), .hdrIn({hdrDw3, hdrDw2, hdrDw1, hdrDw0}),
    .pfxIn(pfxWord), .pfxPresent(pfxPresent), .tsIn(tsCount), .ctrl(ctrl),
    .outValid(outValid), .outReady(outReady), .wordOut(outWord)
  );

  // R5: a full record opens with the all-ones marker
  p_marker_r5: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && hdrReady && fmtSel |=> outValid && outWord == 32'hFFFF_FFFF);
endmodule

// File: tb/trace_rec_fmt_tb_top.sv
module trace_rec_fmt_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, hdrValid, hdrReady, pfxPresent, fmtSel, outValid, outReady, outLast;
  logic [31:0] hdrDw0, hdrDw1, hdrDw2, hdrDw3, pfxWord, tsCount, outWord;
  int nChk = 0, nFail = 0;

  trace_rec_fmt dut_i (.*);

  always @(posedge clk) tsCount <= tsCount + 32'd1;

  localparam int NV = 6;
  localparam logic [31:0] V_H0 [NV] = '{32'h4A80_2C05, 32'hFFFF_FFFF, 32'h0000_0000,
                                         32'h2189_A3FF, 32'h6F00_0001, 32'h5555_AAAA};
  localparam logic [31:0] V_H1 [NV] = '{32'h0100_000F, 32'h1234_5678, 32'hDEAD_BEEF,
                                         32'h0F1E_0001, 32'h8000_0000, 32'hCAFE_F00D};
  localparam logic [31:0] V_H2 [NV] = '{32'h0400_0000, 32'h9ABC_DEF0, 32'h0000_0001,
                                         32'hFFFF_0000, 32'h1111_2222, 32'h3333_4444};
  localparam logic [31:0] V_H3 [NV] = '{32'h4000_8102, 32'h0BAD_F00D, 32'h8000_0000,
                                         32'h0000_FFFF, 32'h5A5A_5A5A, 32'hA5A5_A5A5};
  localparam logic [31:0] V_PF [NV] = '{32'h1357_9BDF, 32'h8765_4321, 32'hFEED_FACE,
                                         32'h0000_0042, 32'h7777_7777, 32'h2468_ACE0};
  localparam logic V_PP [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic V_FM [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic V_ST [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(logic [31:0] h0, h1, h2, h3, pf,
                                          logic pp, logic full, logic [31:0] ts, int i);
    logic [31:0] w [8];
    if (full) begin
      w = '{32'hFFFF_FFFF, pp ? pf : 32'h0, h0, h1, h2, h3, 32'h0, ts};
      return w[i];
    end
    case (i)
      0:       return {h0[30:29], h0[28:24], h0[23], h0[19], h0[16], h0[13], h0[9:0], ts[10:0]};
      1:       return h1;
      2:       return h2;
      default: return h3;
    endcase
  endfunction

  function automatic string wordTag(logic full, int i);
    if (!full) return (i == 0) ? "R7" : "R8";
    case (i)
      0:       return "R5";
      1:       return "R6";
      7:       return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic runRecord(int v);
    logic [31:0] ts;
    int n = V_FM[v] ? 8 : 4;
    @(negedge clk);
    hdrDw0 = V_H0[v]; hdrDw1 = V_H1[v]; hdrDw2 = V_H2[v]; hdrDw3 = V_H3[v];
    pfxWord = V_PF[v]; pfxPresent = V_PP[v]; fmtSel = V_FM[v];
    hdrValid = 1'b1; outReady = 1'b0;
    while (!hdrReady) @(negedge clk);
    ts = tsCount;  // value the accepting edge sees
    @(negedge clk);
    hdrValid = 1'b0; fmtSel = ~V_FM[v]; hdrDw0 = ~V_H0[v]; pfxWord = 32'h0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] e = expWord(V_H0[v], V_H1[v], V_H2[v], V_H3[v], V_PF[v],
                               V_PP[v], V_FM[v], ts, i);
      if (V_ST[v] && (i == 1 || i == n - 1)) begin
        outReady = 1'b0;
        @(negedge clk);
        chk("R10 stalled valid", {31'b0, outValid}, 32'd1);
        chk("R10 stalled word", outWord, e);
      end
      outReady = 1'b1;
      chk("R11 busy hdrReady", {31'b0, hdrReady}, 32'd0);
      chk($sformatf("%s word %0d", wordTag(V_FM[v], i), i), outWord, e);
      chk(V_FM[v] ? "R3 last flag" : "R2 last flag", {31'b0, outLast},
          {31'b0, i == n - 1});
      @(negedge clk);
    end
    outReady = 1'b0;
    chk("R11 ready after last", {31'b0, hdrReady}, 32'd1);
    chk("R2 R3 no extra word", {31'b0, outValid}, 32'd0);
  endtask

  initial begin
    #800000;
    nChk++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    rstN = 1'b0; hdrValid = 1'b0; outReady = 1'b0; pfxPresent = 1'b0; fmtSel = 1'b0;
    hdrDw0 = '0; hdrDw1 = '0; hdrDw2 = '0; hdrDw3 = '0; pfxWord = '0; tsCount = 32'h7F0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'b0, outValid}, 32'd0);
    chk("R1 reset ready", {31'b0, hdrReady}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset valid", {31'b0, outValid}, 32'd0);
    chk("R1 after reset ready", {31'b0, hdrReady}, 32'd1);
    for (int v = 0; v < NV; v++) runRecord(v);
    // directed: timestamp low bits across an 11-bit wrap, compact layout
    @(negedge clk); tsCount = 32'h0000_07FE;
    runRecord(3);
    // directed: back-to-back full then compact with held ready
    runRecord(1);
    runRecord(0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule